// File: doc/BRIEF.md
# Converter Conversion Sequencer and Host Port

This block is the digital control side of a parallel-output sampling converter. A falling edge on the active-low convert-start input begins a conversion. The block then pulls its active-low busy output low for a fixed number of clock cycles. When the conversion ends, the raw result on `raw_i` reaches a holding register. The latching mode decides whether the result moves into the output register at once, or only when the next conversion starts.

A host reads the output register through a port with an output enable, gated by chip-select and read. The host writes an offset word through the same port with a write strobe. The offset word is held on `offset_o` for downstream arithmetic. All host strobes and the convert-start input pass through a two-flop synchronizer, and the block acts on their edges. An asynchronous active-low reset aborts a running conversion and clears every register.

Top module: `sar_seq`

## Requirements
- R1: While `rst_ni` is low, `busy_no` is high, `offset_o` is zero, `data_oe_o` is low and `data_o` is zero. After reset the output register reads back as zero.
- R2: A high-to-low transition on `convst_ni` while idle pulls `busy_no` low at the third rising clock edge after the transition. `busy_no` then stays low for exactly `CONV_CYCLES` cycles.
- R3: A falling edge on `convst_ni` while `busy_no` is low has no effect. It does not lengthen the conversion, and it does not change the output register.
- R4: With `mode_i` = 2'b01, the output register takes the `raw_i` value sampled at the clock edge where `busy_no` returns high.
- R5: With `mode_i` = 2'b10, `busy_no` still returns high at the end of the conversion. The output register takes the previous conversion's result only at the start of the next conversion. The first start after reset loads zero.
- R6: With `mode_i` = 2'b00 or 2'b11, conversions still run and drive `busy_no`, but the output register keeps its value.
- R7: Two clock edges after `cs_ni` and `rd_ni` are both low, `data_oe_o` is high and `data_o` shows the output register. Otherwise `data_oe_o` is low and `data_o` is zero.
- R8: A high-to-low transition of `wr_i` while `cs_ni` is low loads `data_i` into `offset_o`. With `cs_ni` high, the write is ignored.
- R9: Asserting `rst_ni` during a conversion returns `busy_no` high and clears `offset_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| convst_ni | input | 1 | Convert start, active low, falling edge starts a conversion |
| mode_i | input | 2 | Latching mode: 01 latch at end, 10 latch at next start |
| raw_i | input | DW | Raw conversion result from the analog core |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_i | input | 1 | Write strobe, captured on falling edge |
| data_i | input | DW | Write data from the host bus |
| data_o | output | DW | Read data to the host bus |
| data_oe_o | output | 1 | Output enable for the host bus driver |
| busy_no | output | 1 | Busy, low during a conversion |
| offset_o | output | DW | Stored offset word |

## Verification
A wrong conversion counter shows up in the length of the `busy_no` low pulse, so the bench measures every pulse to the exact cycle. A wrong latch selection, or stale content in the holding register, shows up at the next read: the wrong word appears within three cycles of the read strobe. Two consecutive mode-2 conversions are enough to expose a one-sample delay that is missing or doubled. A fault in the write path or in reset clearing shows up on `offset_o` three cycles after the write strobe falls, or immediately when reset is asserted.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    LATCH_RSVD_LO = 2'b00,
    LATCH_AT_DONE = 2'b01,
    LATCH_AT_NEXT = 2'b10,
    LATCH_RSVD_HI = 2'b11
  } latch_mode_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int CONV_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sar_result.sv
module sar_result
  import sar_seq_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  latch_mode_e   mode_i,
  input  logic          start_i,
  input  logic          done_i,
  input  logic [DW-1:0] raw_i,
  output logic [DW-1:0] dout_o
);
  logic [DW-1:0] pend_q;
  logic [DW-1:0] dout_q;

  // pend_q holds the latest finished sample for the deferred mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      dout_q <= '0;
    end else begin
      if (done_i) pend_q <= raw_i;
      if (done_i && mode_i == LATCH_AT_DONE)
        dout_q <= raw_i;
      else if (start_i && mode_i == LATCH_AT_NEXT)
        dout_q <= pend_q;
    end
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/sar_host.sv
module sar_host #(
  parameter int DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_n_s_i,
  input  logic          rd_n_s_i,
  input  logic          wr_s_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] dout_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic [DW-1:0] offset_o
);
  logic          wr_prev_q;
  logic          wr_fall;
  logic [DW-1:0] ofs_q;

  assign wr_fall = wr_prev_q && !wr_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev_q <= 1'b0;
      ofs_q     <= '0;
    end else begin
      wr_prev_q <= wr_s_i;
      if (wr_fall && !cs_n_s_i) ofs_q <= data_i;
    end
  end

  assign data_oe_o = !cs_n_s_i && !rd_n_s_i;
  assign data_o    = data_oe_o ? dout_i : '0;
  assign offset_o  = ofs_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int DW = 14,
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          convst_ni,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] raw_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          busy_no,
  output logic [DW-1:0] offset_o
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1110;

  logic [NSYNC-1:0] sync_s;
  logic             conv_s, cs_s, rd_s, wr_s;
  logic             conv_prev_q;
  logic             conv_fall, start, busy, done;
  logic [DW-1:0]    dout_w;

  sar_sync #(.N(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({convst_ni, cs_ni, rd_ni, wr_i}),
    .q_o   (sync_s)
  );
  assign {conv_s, cs_s, rd_s, wr_s} = sync_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) conv_prev_q <= 1'b1;
    else         conv_prev_q <= conv_s;

  assign conv_fall = conv_prev_q && !conv_s;
  assign start     = conv_fall && !busy;

  sar_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy),
    .done_o (done)
  );

  sar_result #(.DW(DW)) u_result (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (latch_mode_e'(mode_i)),
    .start_i(start),
    .done_i (done),
    .raw_i  (raw_i),
    .dout_o (dout_w)
  );

  sar_host #(.DW(DW)) u_host (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_s_i (cs_s),
    .rd_n_s_i (rd_s),
    .wr_s_i   (wr_s),
    .data_i   (data_i),
    .dout_i   (dout_w),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .offset_o (offset_o)
  );

  assign busy_no = !busy;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int DW = 14,
  parameter int CONV_CYCLES = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_no,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] raw_i,
  input logic          cs_ni,
  input logic          rd_ni,
  input logic          data_oe_o,
  input logic [DW-1:0] dout_q,
  input logic [DW-1:0] pend_q,
  input logic [DW-1:0] offset_o
);
  localparam int LW = $clog2(CONV_CYCLES + 2);
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                              lo_cnt <= '0;
    else if (busy_no)                         lo_cnt <= '0;
    else if (lo_cnt != LW'(CONV_CYCLES + 1))  lo_cnt <= lo_cnt + 1'b1;

  always @(posedge clk_i)
    if (!rst_ni) a_reset_idle_r1: assert (busy_no && offset_o == '0);

  p_busy_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> lo_cnt < LW'(CONV_CYCLES));

  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no) |-> lo_cnt == LW'(CONV_CYCLES));

  p_load_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_no) && $past(mode_i) == 2'b01) |-> dout_q == $past(raw_i));

  p_load_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_no) && $past(mode_i) == 2'b10) |-> dout_q == $past(pend_q));

  p_hold_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && $past(!busy_no)) |-> $stable(dout_q));

  p_oe_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!$past(cs_ni, 2) && !$past(rd_ni, 2)));
endmodule

bind sar_seq sar_seq_checker #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_no  (busy_no),
  .mode_i   (mode_i),
  .raw_i    (raw_i),
  .cs_ni    (cs_ni),
  .rd_ni    (rd_ni),
  .data_oe_o(data_oe_o),
  .dout_q   (dout_w),
  .pend_q   (u_result.pend_q),
  .offset_o (offset_o)
);

// File: tb/sar_seq_bench.sv
`timescale 1ns/1ps
module sar_seq_bench;
  localparam int DW = 14;
  localparam int CONV = 12;
  localparam logic [DW-1:0] MASK = '1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          convst_ni = 1'b1;
  logic [1:0]    mode_i = 2'b01;
  logic [DW-1:0] raw_i = '0;
  logic          cs_ni = 1'b1;
  logic          rd_ni = 1'b1;
  logic          wr_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;
  logic          busy_no;
  logic [DW-1:0] offset_o;

  int checks = 0;
  int errs = 0;
  bit done_flag = 0;
  logic [DW-1:0] exp_reg;

  always #2.5 clk_i = ~clk_i;

  sar_seq #(.DW(DW), .CONV_CYCLES(CONV)) u_sar_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .convst_ni(convst_ni), .mode_i(mode_i),
    .raw_i(raw_i), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_i(wr_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .busy_no(busy_no), .offset_o(offset_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  // one conversion; inject > 0 pulses convst again at that busy cycle
  task automatic conv(input logic [DW-1:0] raw, input int inject);
    int n;
    @(negedge clk_i);
    raw_i = raw;
    convst_ni = 1'b0;
    @(negedge clk_i);
    convst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_no == 1'b1, "R2 busy before third edge", busy_no, 1);
    @(negedge clk_i);
    chk(busy_no == 1'b0, "R2 busy at third edge", busy_no, 0);
    n = 0;
    while (!busy_no && n < 4 * CONV) begin
      n++;
      if (n == inject) convst_ni = 1'b0;
      else convst_ni = 1'b1;
      @(negedge clk_i);
    end
    convst_ni = 1'b1;
    if (inject > 0) chk(n == CONV, "R3 length with extra start", n, CONV);
    else chk(n == CONV, "R2 busy length", n, CONV);
    repeat (3) @(negedge clk_i);
    chk(busy_no == 1'b1, "R3 no restart", busy_no, 1);
  endtask

  task automatic rd_check(input logic [DW-1:0] exp, input string req);
    @(negedge clk_i);
    cs_ni = 1'b0;
    rd_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(data_oe_o && data_o == exp, req, data_o, exp);
    cs_ni = 1'b1;
    rd_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!data_oe_o && data_o == '0, "R7 released", data_o, 0);
  endtask

  task automatic wr_word(input logic [DW-1:0] v, input logic cs);
    @(negedge clk_i);
    cs_ni = cs;
    data_i = v;
    wr_i = 1'b1;
    repeat (2) @(negedge clk_i);
    wr_i = 1'b0;
    repeat (4) @(negedge clk_i);
    cs_ni = 1'b1;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1: reset state
    chk(busy_no && offset_o == '0 && !data_oe_o && data_o == '0,
        "R1 reset outputs", {busy_no, data_oe_o}, 2);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    rd_check('0, "R1 output register zero");

    // R4: latch at end of conversion, swept
    mode_i = 2'b01;
    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] v;
      v = (i == 0) ? '0 : (i == 1) ? MASK : DW'((i * 32'h0B3D + 32'h0123)) & MASK;
      conv(v, 0);
      rd_check(v, "R4 mode01 result");
    end

    // R5: deferred latch; first start after reset gives zero
    do_reset();
    mode_i = 2'b10;
    exp_reg = '0;
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] v;
      v = DW'((i * 32'h1357 + 32'h0A5A)) & MASK;
      conv(v, 0);
      rd_check(exp_reg, "R5 mode10 one-sample delay");
      exp_reg = v;
    end

    // R3: start while busy ignored (mode10 shows any stray load)
    conv(14'h2222, 3);
    rd_check(exp_reg, "R3 ignored start kept register");
    exp_reg = 14'h2222;
    conv(14'h0111, 0);
    rd_check(exp_reg, "R3 pending intact");

    // R6: reserved modes leave output register
    mode_i = 2'b00;
    conv(14'h1F0F, 0);
    rd_check(exp_reg, "R6 mode00 hold");
    mode_i = 2'b11;
    conv(14'h30F0, 0);
    rd_check(exp_reg, "R6 mode11 hold");

    // R7: read strobe without chip select
    @(negedge clk_i);
    rd_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!data_oe_o && data_o == '0, "R7 rd without cs", data_oe_o, 0);
    rd_ni = 1'b1;

    // R8: offset writes
    for (int i = 0; i < 4; i++) begin
      logic [DW-1:0] v;
      v = DW'((i * 32'h2A5B + 32'h0011)) & MASK;
      wr_word(v, 1'b0);
      chk(offset_o == v, "R8 offset write", offset_o, v);
      exp_reg = v;
    end
    wr_word(14'h3C3C, 1'b1);
    chk(offset_o == exp_reg, "R8 write without cs ignored", offset_o, exp_reg);

    // R9: reset during conversion
    mode_i = 2'b01;
    @(negedge clk_i);
    raw_i = 14'h1234;
    convst_ni = 1'b0;
    @(negedge clk_i);
    convst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(busy_no == 1'b0, "R9 conversion running", busy_no, 0);
    #1 rst_ni = 1'b0;
    #0.5;
    chk(busy_no == 1'b1 && offset_o == '0, "R9 abort on reset", offset_o, 0);
    @(negedge clk_i);
    convst_ni = 1'b0;
    @(negedge clk_i);
    convst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(busy_no == 1'b1, "R1 held in reset", busy_no, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    rd_check('0, "R1 register cleared after abort");
    conv(14'h0ABC, 0);
    rd_check(14'h0ABC, "R4 after abort");

    finish_run();
  end
endmodule